// File: doc/BRIEF.md
# Single-Channel DMA Block Transfer Sequencer

This block is one DMA channel. Software loads a source address, a destination address, a byte count and a control word through a small register port. The channel then walks the block one bus cycle at a time on a simple master-side bus: it raises a request with an address, a direction and a size, and waits for an acknowledge before it moves on. A status word reports completion and whether the channel is busy.

In dual-address mode each transfer is a read at the source followed by a write of the captured beat to the destination. In single-address mode each transfer is one bus cycle at the source address, and its direction comes from a control bit. A channel starts either from a start bit written by software or from an external request pin. In the second case a fixed start latency applies before the first bus cycle. Writing one to the status DONE bit stops an active channel at once.

Register select codes on `cfg_sel`: 0 source address, 1 destination address, 2 byte count, 3 control, 4 status. Control bits: [0] start (write-only, reads 0), [1] external-request enable, [2] single-address mode, [3] source increment enable, [4] destination increment enable, [5] single-mode direction (1 = write), [7:6] source size, [9:8] destination size. Size codes: 0 byte (step 1), 1 word (2), 2 longword (4), 3 line (16). Status bits: [0] DONE, [1] BUSY.

Top module: `dma_seq`

## Requirements
- R1: After each completed transfer with control bit 3 set, the source address advances by 1, 2, 4 or 16 for source size code 0, 1, 2 or 3.
- R2: After each completed dual-mode transfer with control bit 4 set, the destination address advances by 1, 2, 4 or 16 for destination size code 0, 1, 2 or 3.
- R3: With a side's increment enable clear, that side's address register keeps its value across every transfer.
- R4: The byte count drops by the source step after each transfer, and goes to zero when it is not larger than the step. When it reaches zero the channel sets DONE (status bit 0), clears BUSY (status bit 1) and stops requesting the bus.
- R5: With control bit 1 clear, a control write with bit 0 set raises `bus_req` in the cycle after the write edge, at the source address.
- R6: With control bit 1 set, an idle channel keeps `bus_req` low until `dreq` is sampled high. `bus_req` then rises exactly REQ_LATENCY (default 4) clock edges after the edge that sampled `dreq`.
- R7: In dual mode a transfer is a read (`bus_wr`=0, source size) at the source address, then a write (`bus_wr`=1, destination size) at the destination address carrying the read beat. Each cycle holds its address, direction and size until `bus_ack`.
- R8: In single mode each transfer is one bus cycle at the source address with `bus_wr` equal to control bit 5, and the destination register is left unchanged.
- R9: A status write with bit 0 set stops an active channel (`bus_req` low in the next cycle) and clears DONE.
- R10: While DONE is set, a start bit or `dreq` is ignored: no bus cycle, and the count is unchanged.
- R11: A control write takes effect at once. Changing the source size while a read is pending changes `bus_size` in the next cycle.
- R12: A start with a byte count of zero sets DONE and issues no bus cycle.
- R13: After reset every register reads zero and `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` (combinational) |
| dreq | input | 1 | External start request |
| bus_req | output | 1 | Bus cycle request |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wr | output | 1 | Bus cycle direction, 1 = write |
| bus_size | output | 2 | Bus cycle size code |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | DATA_W | Read beat from the bus |
| bus_wdata | output | DATA_W | Write beat to the bus |

## Verification
The assertions assume that `bus_ack` is raised only while `bus_req` is high, and that software does not rewrite an address or count register while a bus cycle of that channel is pending. The hold property is written to be vacuous in any cycle with a register write. The bench's bus responder acknowledges only a request it observes, with zero or more wait states. Every register write in the bench aimed at a running channel is a control or status write, so the address and count registers are never changed under an active transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_LINE = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RD   = 2'd2,
      ST_WR   = 2'd3
   } chan_state_e;

   // control word bits [9:1]; bit 0 is the write-only start strobe
   typedef struct packed {
      logic [1:0] dsz;
      logic [1:0] ssz;
      logic       single_wr;
      logic       dinc;
      logic       sinc;
      logic       single;
      logic       ext_en;
   } chan_ctrl_t;

   localparam logic [2:0] SEL_SRC  = 3'd0;
   localparam logic [2:0] SEL_DST  = 3'd1;
   localparam logic [2:0] SEL_CNT  = 3'd2;
   localparam logic [2:0] SEL_CTRL = 3'd3;
   localparam logic [2:0] SEL_STAT = 3'd4;

   function automatic logic [4:0] size_step(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_step = 5'd1;
         SZ_WORD: size_step = 5'd2;
         SZ_LONG: size_step = 5'd4;
         default: size_step = 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/dma_seq_addr_unit.sv
module dma_seq_addr_unit
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              advance,
   input  logic              inc_en,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] q
);

   logic [ADDR_W-1:0] step;
   assign step = ADDR_W'(size_step(size));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (load)             q <= load_val;
      else if (advance && inc_en) q <= q + step;
   end

   // R3: with no load and no enabled advance, the address holds
   a_r3_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(advance && inc_en)) |=> $stable(q));

endmodule

// File: rtl/dma_seq_lat_timer.sv
module dma_seq_lat_timer #(
   parameter int LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic cancel,
   output logic fire
);

   if (LAT < 1) begin : g_bad_lat
      $error("dma_seq_lat_timer: LAT must be at least 1");
   end

   if (LAT == 1) begin : g_direct
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      run_q <= 1'b0;
         else if (cancel) run_q <= 1'b0;
         else if (arm)    run_q <= 1'b1;
         else             run_q <= 1'b0;
      end
      assign fire = run_q;
   end else begin : g_count
      localparam int CW = $clog2(LAT);
      localparam int AW = $clog2(LAT + 1);
      logic [CW-1:0] cnt_q;
      logic          run_q;
      logic [AW-1:0] age_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else if (cancel) begin
            run_q <= 1'b0;
         end else if (arm) begin
            run_q <= 1'b1;
            cnt_q <= CW'(LAT - 1);
         end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
         end
      end
      assign fire = run_q && (cnt_q == '0);

      // independent age counter, used only by the latency check
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   age_q <= '0;
         else if (arm)                                 age_q <= '0;
         else if (run_q && (age_q < AW'(LAT)))         age_q <= age_q + 1'b1;
      end

      // R6: fire never comes earlier than LAT-1 cycles after arming
      a_r6_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
         fire |-> (age_q >= AW'(LAT - 1)));
   end

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  chan_ctrl_t        ctrl,
   input  logic              start_req,
   input  logic              abort,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_load_val,
   input  logic              dreq,
   input  logic              fire,
   input  logic [ADDR_W-1:0] src_q,
   input  logic [ADDR_W-1:0] dst_q,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              arm,
   output logic              finish,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              done_q,
   output logic              busy,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_wr,
   output logic [1:0]        bus_size,
   output logic [DATA_W-1:0] bus_wdata
);

   chan_state_e       st_q, st_d;
   logic [CNT_W-1:0]  cnt_d, step;
   logic              done_d, go_int, go_ext;
   logic [DATA_W-1:0] buf_q, buf_d;

   assign step   = CNT_W'(size_step(ctrl.ssz));
   assign go_int = start_req && (st_q == ST_IDLE) && !done_q;
   assign go_ext = ctrl.ext_en && dreq && (st_q == ST_IDLE) && !done_q;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      done_d = done_q;
      buf_d  = buf_q;
      arm    = 1'b0;
      finish = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (go_int || go_ext) begin
               if (cnt_q == '0) done_d = 1'b1;
               else if (go_int) st_d = ST_RD;
               else begin
                  st_d = ST_WAIT;
                  arm  = 1'b1;
               end
            end
         end
         ST_WAIT: if (fire) st_d = ST_RD;
         ST_RD: begin
            if (bus_ack) begin
               buf_d = bus_rdata;
               if (ctrl.single) finish = 1'b1;
               else             st_d = ST_WR;
            end
         end
         default: if (bus_ack) finish = 1'b1;
      endcase
      if (finish) begin
         if (cnt_q <= step) begin
            cnt_d  = '0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
         end else begin
            cnt_d = cnt_q - step;
            st_d  = ST_RD;
         end
      end
      if (cnt_load) cnt_d = cnt_load_val;
      if (abort) begin
         st_d   = ST_IDLE;
         done_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
         buf_q  <= '0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         done_q <= done_d;
         buf_q  <= buf_d;
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign bus_req   = (st_q == ST_RD) || (st_q == ST_WR);
   assign bus_addr  = (st_q == ST_WR) ? dst_q : src_q;
   assign bus_wr    = (st_q == ST_WR) ? 1'b1 : (ctrl.single && ctrl.single_wr);
   assign bus_size  = (st_q == ST_WR) ? ctrl.dsz : ctrl.ssz;
   assign bus_wdata = buf_q;

   // R9: a DONE write stops the channel and clears DONE
   a_r9_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!bus_req && !done_q));

   // R12: a start with zero count completes without a bus cycle
   a_r12_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      ((go_int || go_ext) && (cnt_q == '0) && !abort && !cnt_load)
      |=> (done_q && !bus_req));

   // R4: while active the count never grows unless software loads it
   a_r4_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cnt_load) |=> (cnt_q <= $past(cnt_q)));

   // R10: an idle channel with DONE set stays off the bus
   a_r10_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !busy && !abort) |=> !bus_req);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 24,
   parameter int DATA_W      = 32,
   parameter int REQ_LATENCY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              dreq,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_wr,
   output logic [1:0]        bus_size,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] bus_wdata
);

   localparam int REG_W  = 32;
   localparam int CTRL_W = $bits(chan_ctrl_t);
   localparam int SIDES  = 2;

   if (ADDR_W < 8 || ADDR_W > REG_W) begin : g_bad_addr
      $error("dma_seq: ADDR_W out of range");
   end
   if (CNT_W < 5 || CNT_W > REG_W) begin : g_bad_cnt
      $error("dma_seq: CNT_W out of range");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("dma_seq: DATA_W too small");
   end

   chan_ctrl_t        ctrl_q;
   logic              wr_src, wr_dst, wr_cnt, wr_ctrl, wr_stat;
   logic              start_req, abort, arm, fire, finish;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q, busy;
   logic [ADDR_W-1:0] side_q    [SIDES];
   logic              side_load [SIDES];
   logic              side_adv  [SIDES];
   logic              side_inc  [SIDES];
   logic [1:0]        side_size [SIDES];

   assign wr_src  = cfg_we && (cfg_sel == SEL_SRC);
   assign wr_dst  = cfg_we && (cfg_sel == SEL_DST);
   assign wr_cnt  = cfg_we && (cfg_sel == SEL_CNT);
   assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
   assign wr_stat = cfg_we && (cfg_sel == SEL_STAT);

   assign start_req = wr_ctrl && cfg_wdata[0] && !cfg_wdata[1];
   assign abort     = wr_stat && cfg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= chan_ctrl_t'(cfg_wdata[CTRL_W:1]);
   end

   assign side_load[0] = wr_src;
   assign side_load[1] = wr_dst;
   assign side_adv[0]  = finish;
   assign side_adv[1]  = finish && !ctrl_q.single;
   assign side_inc[0]  = ctrl_q.sinc;
   assign side_inc[1]  = ctrl_q.dinc;
   assign side_size[0] = ctrl_q.ssz;
   assign side_size[1] = ctrl_q.dsz;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      dma_seq_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (side_load[s]),
         .load_val (cfg_wdata[ADDR_W-1:0]),
         .advance  (side_adv[s]),
         .inc_en   (side_inc[s]),
         .size     (side_size[s]),
         .q        (side_q[s])
      );
   end

   dma_seq_lat_timer #(.LAT(REQ_LATENCY)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .cancel (abort),
      .fire   (fire)
   );

   dma_seq_ctrl #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl         (ctrl_q),
      .start_req    (start_req),
      .abort        (abort),
      .cnt_load     (wr_cnt),
      .cnt_load_val (cfg_wdata[CNT_W-1:0]),
      .dreq         (dreq),
      .fire         (fire),
      .src_q        (side_q[0]),
      .dst_q        (side_q[1]),
      .bus_ack      (bus_ack),
      .bus_rdata    (bus_rdata),
      .arm          (arm),
      .finish       (finish),
      .cnt_q        (cnt_q),
      .done_q       (done_q),
      .busy         (busy),
      .bus_req      (bus_req),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_size     (bus_size),
      .bus_wdata    (bus_wdata)
   );

   always_comb begin
      cfg_rdata = '0;
      case (cfg_sel)
         SEL_SRC:  cfg_rdata[ADDR_W-1:0] = side_q[0];
         SEL_DST:  cfg_rdata[ADDR_W-1:0] = side_q[1];
         SEL_CNT:  cfg_rdata[CNT_W-1:0]  = cnt_q;
         SEL_CTRL: cfg_rdata[CTRL_W:1]   = ctrl_q;
         SEL_STAT: cfg_rdata[1:0]        = {busy, done_q};
         default:  cfg_rdata = '0;
      endcase
   end

   // R7: a pending bus cycle keeps address, direction and size until acknowledged
   a_r7_cycle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !cfg_we)
      |=> (bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_size)));

   // R13: nothing is requested in the first cycle out of reset
   a_r13_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !bus_req);

endmodule

// File: tb/dma_seq_tb_top.sv
module dma_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        dreq = 1'b0;
   logic        bus_req;
   logic [31:0] bus_addr;
   logic        bus_wr;
   logic [1:0]  bus_size;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic [31:0] bus_wdata;

   int checks = 0;
   int failures = 0;
   int wait_states = 0;
   int n_log = 0;
   logic [31:0] log_addr  [64];
   logic [31:0] log_wdata [64];
   logic        log_wr    [64];
   logic [1:0]  log_size  [64];

   always #2 clk = ~clk;

   dma_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_size(bus_size), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .bus_wdata(bus_wdata)
   );

   typedef struct packed {
      logic [1:0]  ssz;
      logic [1:0]  dsz;
      logic        sinc;
      logic        dinc;
      logic [15:0] cnt;
      logic [7:0]  xf;
      logic [15:0] esrc;
      logic [15:0] edst;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 2'd0, 1'b1, 1'b1, 16'd3,  8'd3, 16'h0103, 16'h0203},
      '{2'd1, 2'd2, 1'b1, 1'b1, 16'd6,  8'd3, 16'h0106, 16'h020C},
      '{2'd2, 2'd3, 1'b1, 1'b1, 16'd8,  8'd2, 16'h0108, 16'h0220},
      '{2'd3, 2'd0, 1'b1, 1'b0, 16'd32, 8'd2, 16'h0120, 16'h0200},
      '{2'd2, 2'd1, 1'b0, 1'b1, 16'd5,  8'd2, 16'h0100, 16'h0204}
   };

   function automatic int stp(input logic [1:0] s);
      return (s == 2'd3) ? 16 : (1 << s);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [2:0] sel, output logic [31:0] data);
      cfg_sel = sel;
      #1;
      data = cfg_rdata;
   endtask

   // bus responder: acknowledges after wait_states idle cycles
   task automatic serve();
      int wc = 0;
      n_log = 0;
      for (int it = 0; it < 400; it++) begin
         if (!bus_req) break;
         if (wc == wait_states) begin
            bus_ack = 1'b1;
            bus_rdata = bus_addr ^ 32'hA5A5_0000;
            if (n_log < 64) begin
               log_addr[n_log]  = bus_addr;
               log_wr[n_log]    = bus_wr;
               log_size[n_log]  = bus_size;
               log_wdata[n_log] = bus_wdata;
            end
            n_log++;
            wc = 0;
         end else begin
            bus_ack = 1'b0;
            wc++;
         end
         @(negedge clk);
      end
      bus_ack = 1'b0;
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      report();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13: reset state
      for (int s = 0; s < 5; s++) begin
         cfg_read(3'(s), rd);
         chk("R13 register after reset", rd, 32'd0);
      end
      chk("R13 bus_req after reset", {31'd0, bus_req}, 32'd1 - 32'd1);

      // table walk: dual-address transfers (R1 R2 R3 R4 R5 R7)
      for (int i = 0; i < NV; i++) begin
         int sstep, dstep;
         sstep = stp(VEC[i].ssz);
         dstep = stp(VEC[i].dsz);
         wait_states = i % 2;
         cfg_write(3'd4, 32'd1);
         cfg_write(3'd0, 32'h100);
         cfg_write(3'd1, 32'h200);
         cfg_write(3'd2, {16'd0, VEC[i].cnt});
         cfg_write(3'd3, (32'(VEC[i].dsz) << 8) | (32'(VEC[i].ssz) << 6) |
                         (32'(VEC[i].dinc) << 4) | (32'(VEC[i].sinc) << 3) | 32'd1);
         chk("R5 bus_req after start", {31'd0, bus_req}, 32'd1);
         chk("R5 first address", bus_addr, 32'h100);
         serve();
         chk("R7 bus cycle count", 32'(n_log), 32'(2 * VEC[i].xf));
         for (int k = 0; k < n_log && k < 64; k++) begin
            int j;
            j = k / 2;
            if (k % 2 == 0) begin
               chk("R1 read address", log_addr[k], 32'h100 + (VEC[i].sinc ? 32'(j * sstep) : 32'd0));
               chk("R7 read direction", {31'd0, log_wr[k]}, 32'd0);
               chk("R7 read size", {30'd0, log_size[k]}, {30'd0, VEC[i].ssz});
            end else begin
               chk("R2 write address", log_addr[k], 32'h200 + (VEC[i].dinc ? 32'(j * dstep) : 32'd0));
               chk("R7 write direction", {31'd0, log_wr[k]}, 32'd1);
               chk("R7 write size", {30'd0, log_size[k]}, {30'd0, VEC[i].dsz});
               chk("R7 write data", log_wdata[k], log_addr[k-1] ^ 32'hA5A5_0000);
            end
         end
         cfg_read(3'd0, rd); chk("R1 final source", rd, {16'd0, VEC[i].esrc});
         cfg_read(3'd1, rd); chk("R2 R3 final destination", rd, {16'd0, VEC[i].edst});
         cfg_read(3'd2, rd); chk("R4 final count", rd, 32'd0);
         cfg_read(3'd4, rd); chk("R4 status done not busy", rd, 32'd1);
      end
      wait_states = 0;

      // R8: single-address write transfers at the source address
      cfg_write(3'd4, 32'd1);
      cfg_write(3'd0, 32'h300);
      cfg_write(3'd1, 32'h400);
      cfg_write(3'd2, 32'd8);
      cfg_write(3'd3, 32'h0AD);
      serve();
      chk("R8 single cycle count", 32'(n_log), 32'd2);
      chk("R8 first address", log_addr[0], 32'h300);
      chk("R8 second address", log_addr[1], 32'h304);
      chk("R8 direction", {30'd0, log_wr[0], log_wr[1]}, 32'd3);
      cfg_read(3'd1, rd); chk("R8 destination untouched", rd, 32'h400);
      cfg_read(3'd0, rd); chk("R8 source advanced", rd, 32'h308);

      // R12: zero count
      cfg_write(3'd4, 32'd1);
      cfg_write(3'd2, 32'd0);
      cfg_write(3'd3, 32'h019);
      chk("R12 no bus cycle", {31'd0, bus_req}, 32'd0);
      cfg_read(3'd4, rd); chk("R12 done set", rd, 32'd1);

      // R10: start ignored while DONE set
      cfg_write(3'd2, 32'd4);
      cfg_write(3'd3, 32'h019);
      chk("R10 no request", {31'd0, bus_req}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R10 still no request", {31'd0, bus_req}, 32'd0);
      cfg_read(3'd2, rd); chk("R10 count unchanged", rd, 32'd4);
      cfg_read(3'd4, rd); chk("R10 status", rd, 32'd1);

      // R9: abort an active channel
      cfg_write(3'd4, 32'd1);
      cfg_read(3'd4, rd); chk("R9 done cleared", rd, 32'd0);
      cfg_write(3'd0, 32'h500);
      cfg_write(3'd1, 32'h600);
      cfg_write(3'd2, 32'd64);
      cfg_write(3'd3, 32'h019);
      chk("R9 active before abort", {31'd0, bus_req}, 32'd1);
      cfg_write(3'd4, 32'd1);
      chk("R9 request dropped", {31'd0, bus_req}, 32'd0);
      cfg_read(3'd4, rd); chk("R9 status after abort", rd, 32'd0);
      cfg_read(3'd2, rd); chk("R9 count kept", rd, 32'd64);
      repeat (3) @(negedge clk);
      chk("R9 stays stopped", {31'd0, bus_req}, 32'd0);

      // R11: size change while a read is pending
      cfg_write(3'd0, 32'h700);
      cfg_write(3'd2, 32'd8);
      cfg_write(3'd3, 32'h019);
      chk("R11 byte size first", {30'd0, bus_size}, 32'd0);
      cfg_write(3'd3, 32'h058);
      chk("R11 size follows control", {30'd0, bus_size}, 32'd1);
      chk("R11 request kept", {31'd0, bus_req}, 32'd1);
      cfg_write(3'd4, 32'd1);

      // R6: external request latency
      cfg_write(3'd0, 32'h800);
      cfg_write(3'd1, 32'h900);
      cfg_write(3'd2, 32'd2);
      cfg_write(3'd3, 32'h01A);
      repeat (3) @(negedge clk);
      chk("R6 idle without dreq", {31'd0, bus_req}, 32'd0);
      dreq = 1'b1;
      @(posedge clk);
      @(negedge clk);
      dreq = 1'b0;
      chk("R6 low after sampling edge", {31'd0, bus_req}, 32'd0);
      for (int e = 1; e < 4; e++) begin
         @(negedge clk);
         chk("R6 low during latency", {31'd0, bus_req}, 32'd0);
      end
      @(negedge clk);
      chk("R6 request at fourth edge", {31'd0, bus_req}, 32'd1);
      serve();
      chk("R6 block cycles", 32'(n_log), 32'd4);
      cfg_read(3'd4, rd); chk("R6 done", rd, 32'd1);

      report();
   end

endmodule